// File: doc/BRIEF.md
# Bulk Endpoint Halt Handler

This block tracks the stall state of a single bulk endpoint that consumes a circular ring of transfer descriptors. Each time the descriptor engine finishes one descriptor, it reports a completion strobe together with a 3-bit result class. A successful result moves the consumer index one slot forward and raises a success event. A failing result stalls the endpoint instead. It raises one error event that carries the class, and it keeps the consumer index on the descriptor that failed.

The stall persists until the remote host sends a clear-halt request. The clear drops the stall and resets the endpoint state. It then moves the consumer index one slot past the failing descriptor, so that descriptor is never replayed. Hardware never retries a descriptor on its own. Software reads the error event and decides whether to queue the work again. The ring depth is a parameter, and the index wraps to zero after the last slot.

Top module: `bulk_ep_halt`

## Requirements
- R1: After reset, `halted` is 0, `evt_valid` is 0, and `deq_idx` is 0.
- R2: A completion with class 0 (success) on a running endpoint gives a one-cycle `evt_valid` with `evt_code` 0 in the cycle after the strobe, and `deq_idx` increases by one.
- R3: A completion with class 1 (data buffer), 2 (parameter), 3 (descriptor), 4 (vendor-defined) or 7 (undefined) on a running endpoint sets `halted` and gives exactly one `evt_valid` pulse carrying that class, both in the cycle after the strobe. `deq_idx` does not change.
- R4: The unassigned classes 5 and 6 are handled as undefined: the endpoint halts and `evt_code` reads 7.
- R5: While `halted` is 1, completion strobes are discarded: no event is raised, and `deq_idx` holds.
- R6: A `clr_halt` strobe while halted clears `halted` in the next cycle and advances `deq_idx` by one, past the failing descriptor. It raises no event, and no completion is replayed.
- R7: `deq_idx` wraps from RING_DEPTH-1 to 0, on both the success path and the clear-halt path.
- R8: A `clr_halt` strobe while the endpoint is not halted has no effect on `halted`, `deq_idx` or the event outputs.
- R9: When `clr_halt` and a completion arrive in the same cycle on a halted endpoint, the clear is applied and the completion is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | One-cycle strobe: a descriptor has finished |
| cpl_class | input | 3 | Result class of the finished descriptor |
| clr_halt | input | 1 | One-cycle strobe: clear-halt request from the remote host |
| halted | output | 1 | Endpoint is stalled |
| evt_valid | output | 1 | One-cycle transfer event strobe |
| evt_code | output | 3 | Result code carried by the event |
| deq_idx | output | IDXW | Ring slot of the next descriptor to consume |

## Verification
The bench builds the block with RING_DEPTH set to 5. This depth is not a power of two, so the wrap at slot 4 must come from the explicit limit compare and not from the natural overflow of the index. The small depth also puts the wrap within a few strobes. The bench uses it to halt on the last slot and show that the clear-halt skip wraps as well. Every error class, including the two unassigned codes, is run through a full cycle of halt, ignored completions and clear, starting from different ring positions.

// File: rtl/ephh_pkg.sv
package ephh_pkg;
  typedef logic [2:0] cls_t;

  localparam cls_t CLS_OK      = 3'd0;
  localparam cls_t CLS_DATABUF = 3'd1;
  localparam cls_t CLS_PARAM   = 3'd2;
  localparam cls_t CLS_DESC    = 3'd3;
  localparam cls_t CLS_VENDOR  = 3'd4;
  localparam cls_t CLS_UNDEF   = 3'd7;

  // any class other than success stalls the endpoint
  function automatic logic cls_is_fail(cls_t c);
    return c != CLS_OK;
  endfunction

  // unassigned encodings collapse to the undefined class
  function automatic cls_t cls_report(cls_t c);
    case (c)
      CLS_OK, CLS_DATABUF, CLS_PARAM, CLS_DESC, CLS_VENDOR, CLS_UNDEF: return c;
      default: return CLS_UNDEF;
    endcase
  endfunction
endpackage

// File: rtl/ephh_classify.sv
module ephh_classify
  import ephh_pkg::*;
(
  input  cls_t raw_class,
  output logic fail_hit,
  output cls_t rep_class
);
  always_comb begin
    fail_hit  = cls_is_fail(raw_class);
    rep_class = cls_report(raw_class);
  end
endmodule

// File: rtl/ephh_ring_ptr.sv
module ephh_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  function automatic logic [IDXW-1:0] slot_after(logic [IDXW-1:0] cur);
    return (cur == LAST) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= slot_after(idx);
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);                                          // R7
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx == LAST) |=> idx == '0);                   // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx));                                // R5
endmodule

// File: rtl/ephh_halt_ctl.sv
module ephh_halt_ctl
  import ephh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpl_valid,
  input  logic fail_hit,
  input  cls_t rep_class,
  input  logic clr_halt,
  output logic halted,
  output logic evt_valid,
  output cls_t evt_code,
  output logic ring_adv
);
  logic take_cpl;
  logic take_clr;

  assign take_cpl = cpl_valid && !halted;
  assign take_clr = clr_halt && halted;
  assign ring_adv = (take_cpl && !fail_hit) || take_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= CLS_OK;
    end else begin
      evt_valid <= 1'b0;
      if (take_clr) begin
        halted   <= 1'b0;
        evt_code <= CLS_OK;
      end else if (take_cpl) begin
        evt_valid <= 1'b1;
        evt_code  <= fail_hit ? rep_class : CLS_OK;
        if (fail_hit) halted <= 1'b1;
      end
    end
  end

  AST_HALT_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (evt_valid && evt_code != CLS_OK));  // R3
  AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> !evt_valid);             // R5
  AST_LEAVE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> ($past(clr_halt) && !evt_valid));    // R6
  AST_NO_ODD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code != 3'd5 && evt_code != 3'd6)); // R4
endmodule

// File: rtl/bulk_ep_halt.sv
module bulk_ep_halt
  import ephh_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  localparam int IDXW = (RING_DEPTH < 2) ? 1 : $clog2(RING_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpl_valid,
  input  logic [2:0]      cpl_class,
  input  logic            clr_halt,
  output logic            halted,
  output logic            evt_valid,
  output logic [2:0]      evt_code,
  output logic [IDXW-1:0] deq_idx
);
  logic fail_hit;
  cls_t rep_class;
  logic ring_adv;

  ephh_classify u_cls (
    .raw_class (cpl_class),
    .fail_hit  (fail_hit),
    .rep_class (rep_class)
  );

  ephh_halt_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_valid (cpl_valid),
    .fail_hit  (fail_hit),
    .rep_class (rep_class),
    .clr_halt  (clr_halt),
    .halted    (halted),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .ring_adv  (ring_adv)
  );

  ephh_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ring_adv),
    .idx   (deq_idx)
  );

  AST_FAIL_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !halted && cpl_class != 3'd0) |=> $stable(deq_idx)); // R3
  AST_CLEAR_MOVES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_halt && halted && RING_DEPTH > 1) |=> deq_idx != $past(deq_idx)); // R6
endmodule

// File: tb/bulk_ep_halt_test.sv
module bulk_ep_halt_test;
  localparam int DEPTH = 5;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpl_valid = 1'b0;
  logic [2:0] cpl_class = 3'd0;
  logic clr_halt = 1'b0;
  logic halted;
  logic evt_valid;
  logic [2:0] evt_code;
  logic [IDXW-1:0] deq_idx;

  int n_chk = 0;
  int n_bad = 0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  bulk_ep_halt #(.RING_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_class(cpl_class),
    .clr_halt(clr_halt), .halted(halted), .evt_valid(evt_valid),
    .evt_code(evt_code), .deq_idx(deq_idx)
  );

  task automatic check(string req, string what, int got, int want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  function automatic int wrap_next(int i);
    return (i + 1) % DEPTH;
  endfunction

  // one strobe cycle, then sample at the following falling edge
  task automatic pulse(bit cv, logic [2:0] cc, bit ch);
    @(negedge clk);
    cpl_valid = cv; cpl_class = cc; clr_halt = ch;
    @(negedge clk);
    cpl_valid = 1'b0; clr_halt = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "halted", halted, 0);
    check("R1", "evt_valid", evt_valid, 0);
    check("R1", "deq_idx", deq_idx, 0);
  endtask

  task automatic t_success(string req);
    pulse(1, 3'd0, 0);
    exp_idx = wrap_next(exp_idx);
    check(req, "ok evt_valid", evt_valid, 1);
    check(req, "ok evt_code", evt_code, 0);
    check(req, "ok deq_idx", deq_idx, exp_idx);
    check(req, "ok halted", halted, 0);
    @(negedge clk);
    check(req, "ok event one cycle", evt_valid, 0);
  endtask

  task automatic t_fail_cycle(string req, logic [2:0] cls, int want_code);
    pulse(1, cls, 0);
    check(req, "fail halted", halted, 1);
    check(req, "fail evt_valid", evt_valid, 1);
    check(req, "fail evt_code", evt_code, want_code);
    check(req, "fail deq_idx held", deq_idx, exp_idx);
    // R5: completions while halted are dropped
    pulse(1, 3'd0, 0);
    check("R5", "halted evt_valid", evt_valid, 0);
    check("R5", "halted deq_idx", deq_idx, exp_idx);
    pulse(1, 3'd2, 0);
    check("R5", "halted evt_valid err", evt_valid, 0);
    check("R5", "still halted", halted, 1);
    // R6: clear skips the failing descriptor
    pulse(0, 3'd0, 1);
    exp_idx = wrap_next(exp_idx);
    check("R6", "clear halted", halted, 0);
    check("R6", "clear evt_valid", evt_valid, 0);
    check("R6", "clear deq_idx", deq_idx, exp_idx);
    @(negedge clk);
    check("R6", "no replay event", evt_valid, 0);
  endtask

  task automatic t_clear_idle();
    pulse(0, 3'd0, 1);
    check("R8", "idle clear halted", halted, 0);
    check("R8", "idle clear evt_valid", evt_valid, 0);
    check("R8", "idle clear deq_idx", deq_idx, exp_idx);
  endtask

  task automatic t_clear_and_cpl();
    pulse(1, 3'd3, 0);
    check("R3", "pre halted", halted, 1);
    pulse(1, 3'd0, 1);
    exp_idx = wrap_next(exp_idx);
    check("R9", "both halted", halted, 0);
    check("R9", "both evt_valid", evt_valid, 0);
    check("R9", "both deq_idx", deq_idx, exp_idx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success("R2");
    t_success("R2");
    t_fail_cycle("R3", 3'd1, 1);
    t_fail_cycle("R3", 3'd2, 2);
    t_fail_cycle("R3", 3'd3, 3);
    t_fail_cycle("R3", 3'd4, 4);
    t_fail_cycle("R3", 3'd7, 7);
    t_fail_cycle("R4", 3'd5, 7);
    t_fail_cycle("R4", 3'd6, 7);
    // R7: walk to the last slot on success, then wrap on success
    while (exp_idx != DEPTH - 1) t_success("R7");
    t_success("R7");
    check("R7", "success wrap", deq_idx, 0);
    // R7: halt on the last slot, clear wraps
    while (exp_idx != DEPTH - 1) t_success("R7");
    t_fail_cycle("R7", 3'd1, 1);
    check("R7", "clear wrap", deq_idx, 0);
    t_clear_idle();
    t_clear_and_cpl();
    t_success("R2");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule